// File: doc/BRIEF.md
# Shadow RAM Configuration and Decoder

This block holds the byte-wide configuration space of a host bridge and makes the routing decision for memory cycles that fall into the upper BIOS area. The configuration side has an 8-bit offset, a write strobe, write data and combinational read data. Offsets 0x04 to 0x07 and 0x40 to 0xFF hold writable bytes. Every other offset returns a fixed identification value.

The memory side takes a 20-bit address and a write flag. It asserts exactly one of three selects: send the cycle to DRAM, send it to the boot ROM, or discard a write. The range 0xE0000–0xFFFFF is cut into four 32 KB segments. Each segment has its own shadow enable in register 0x44, and one write-protect bit in register 0x45 covers all shadowed segments. A status output reports whether any segment is shadowed.

Top module: `shadow_bridge_cfg`

## Requirements
- R1: After reset, configuration reads return 0x39, 0x10, 0x96, 0x04 at offsets 0x00–0x03. They return 0x07, 0x00, 0x80, 0x02 at 0x04–0x07, 0x02 at 0x08, and 0x00, 0x00, 0x06 at 0x09–0x0B. Offset 0x0E and every other offset read 0x00.
- R2: A write strobe at offsets 0x04–0x07 or 0x40–0xFF stores the data byte, and the next clock cycle reads it back.
- R3: Writes to offsets 0x00–0x03 and 0x08–0x3F have no effect, and those offsets keep their reset value.
- R4: In a segment whose shadow bit is clear, a read in 0xE0000–0xFFFFF asserts the ROM select, and a write asserts the DRAM select.
- R5: In a segment whose shadow bit is set, a read asserts the DRAM select.
- R6: In a segment whose shadow bit is set, a write asserts the discard output when bit 0 of 0x45 is 1, and the DRAM select when that bit is 0.
- R7: Bits 4, 5, 6 and 7 of 0x44 govern the segments at 0xE0000, 0xE8000, 0xF0000 and 0xF8000, in that order. Bits 3:0 of 0x44 do not affect routing.
- R8: Any memory cycle below 0xE0000 asserts the DRAM select only.
- R9: The shadow-active output equals the OR of bits 7:4 of 0x44.
- R10: Exactly one of the DRAM select, ROM select and discard outputs is high at all times.
- R11: A write to 0x44 or 0x45 leaves routing unchanged during the cycle of the strobe and changes it from the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data at cfg_addr (combinational) |
| mem_addr | input | 20 | Memory cycle address |
| mem_wr | input | 1 | Memory cycle is a write |
| sel_dram | output | 1 | Route cycle to DRAM |
| sel_rom | output | 1 | Route cycle to boot ROM |
| wr_drop | output | 1 | Discard the write |
| shadow_any | output | 1 | At least one segment is shadowed |

## Verification
The only state that routing depends on is five bits: four shadow enables and one protect flag. If one of these bits is wrong, a probe of the affected segment in the first cycle after the write shows the wrong select, and the shadow-active output shows it for the enables. For that reason the bench probes every segment after each change of 0x44. Probing in the strobe cycle itself shows whether a register update lands too early. A corrupted or wrongly writable configuration byte shows on the first read-back of that offset.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;

  localparam int CFG_AW    = 8;
  localparam int CFG_BYTES = 1 << CFG_AW;

  localparam logic [CFG_AW-1:0] OFF_SHADOW = 8'h44;
  localparam logic [CFG_AW-1:0] OFF_PROT   = 8'h45;

  typedef enum logic [1:0] {
    ROUTE_DRAM = 2'd0,
    ROUTE_ROM  = 2'd1,
    ROUTE_DROP = 2'd2
  } route_e;

  function automatic logic cfg_writable(input logic [CFG_AW-1:0] off);
    return ((off >= 8'h04) && (off <= 8'h07)) || (off >= 8'h40);
  endfunction

  function automatic logic [7:0] cfg_reset_byte(input logic [CFG_AW-1:0] off);
    logic [7:0] v;
    case (off)
      8'h00:   v = 8'h39;
      8'h01:   v = 8'h10;
      8'h02:   v = 8'h96;
      8'h03:   v = 8'h04;
      8'h04:   v = 8'h07;
      8'h06:   v = 8'h80;
      8'h07:   v = 8'h02;
      8'h08:   v = 8'h02;
      8'h0B:   v = 8'h06;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_cfg_pkg::*;
#(
  parameter int SEG_COUNT  = 4,
  parameter int SHADOW_LSB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_AW-1:0]    addr,
  input  logic                 we,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [SEG_COUNT-1:0] shadow_en,
  output logic                 wprot
);

  logic [7:0] bytes_q [CFG_BYTES];

  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
    if (cfg_writable(CFG_AW'(i))) begin : g_rw
      logic       en;
      logic [7:0] d;
      logic [7:0] q;

      always_comb begin
        en = we && (addr == CFG_AW'(i));
        d  = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= cfg_reset_byte(CFG_AW'(i));
        else if (en) q <= d;
      end

      assign bytes_q[i] = q;
    end else begin : g_ro
      assign bytes_q[i] = cfg_reset_byte(CFG_AW'(i));
    end
  end

  assign rdata     = bytes_q[addr];
  assign shadow_en = bytes_q[OFF_SHADOW][SHADOW_LSB +: SEG_COUNT];
  assign wprot     = bytes_q[OFF_PROT][0];

endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_cfg_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 15,
  parameter int SEG_COUNT = 4,
  parameter int SEG_FIRST = 28
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic [SEG_COUNT-1:0] shadow_en,
  input  logic                 wprot,
  output logic                 sel_dram,
  output logic                 sel_rom,
  output logic                 wr_drop
);

  localparam int IDX_W = ADDR_W - SEG_SHIFT;

  logic [IDX_W-1:0]     seg_idx;
  logic [SEG_COUNT-1:0] seg_hit;
  logic                 in_area;
  logic                 shadowed;
  route_e               route;

  assign seg_idx = addr[ADDR_W-1:SEG_SHIFT];

  for (genvar k = 0; k < SEG_COUNT; k++) begin : g_seg
    assign seg_hit[k] = (seg_idx == IDX_W'(SEG_FIRST + k));
  end

  assign in_area  = |seg_hit;
  assign shadowed = |(seg_hit & shadow_en);

  always_comb begin
    route = ROUTE_DRAM;
    if (in_area) begin
      if (!shadowed)   route = wr ? ROUTE_DRAM : ROUTE_ROM;
      else if (wr)     route = wprot ? ROUTE_DROP : ROUTE_DRAM;
      else             route = ROUTE_DRAM;
    end
  end

  assign sel_dram = (route == ROUTE_DRAM);
  assign sel_rom  = (route == ROUTE_ROM);
  assign wr_drop  = (route == ROUTE_DROP);

endmodule

// File: rtl/shadow_bridge_cfg.sv
module shadow_bridge_cfg
  import shadow_cfg_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 15,
  parameter int SEG_COUNT = 4,
  parameter int SEG_FIRST = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_wr,
  output logic              sel_dram,
  output logic              sel_rom,
  output logic              wr_drop,
  output logic              shadow_any
);

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [SEG_COUNT-1:0] shadow_en;
  logic                 wprot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  shadow_cfg_regs #(
    .SEG_COUNT  (SEG_COUNT),
    .SHADOW_LSB (4)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .addr      (cfg_addr),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .shadow_en (shadow_en),
    .wprot     (wprot)
  );

  shadow_seg_decode #(
    .ADDR_W    (ADDR_W),
    .SEG_SHIFT (SEG_SHIFT),
    .SEG_COUNT (SEG_COUNT),
    .SEG_FIRST (SEG_FIRST)
  ) u_dec (
    .addr      (mem_addr),
    .wr        (mem_wr),
    .shadow_en (shadow_en),
    .wprot     (wprot),
    .sel_dram  (sel_dram),
    .sel_rom   (sel_rom),
    .wr_drop   (wr_drop)
  );

  assign shadow_any = |shadow_en;

endmodule

// File: rtl/shadow_bridge_chk.sv
module shadow_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cfg_addr,
  input logic        cfg_we,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic [19:0] mem_addr,
  input logic        mem_wr,
  input logic        sel_dram,
  input logic        sel_rom,
  input logic        wr_drop,
  input logic        shadow_any
);

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_dram, sel_rom, wr_drop}) == 1); // R10

  AST_LOW_MEM_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr < 20'hE0000) |-> (sel_dram && !sel_rom && !wr_drop)); // R8

  AST_WRITE_NEVER_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !sel_rom); // R4

  AST_READ_NEVER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr |-> !wr_drop); // R6

  AST_UNSHADOWED_READ_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_any && !mem_wr && mem_addr >= 20'hE0000) |-> sel_rom); // R4

  AST_ANY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we && cfg_addr == 8'h44) |-> $stable(shadow_any)); // R9

endmodule

bind shadow_bridge_cfg shadow_bridge_chk u_chk (.*);

// File: tb/tb_shadow_bridge_cfg.sv
`timescale 1ns/1ps
module tb_shadow_bridge_cfg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_addr;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [19:0] mem_addr;
  logic        mem_wr;
  logic        sel_dram, sel_rom, wr_drop, shadow_any;

  always #2 clk = ~clk;

  shadow_bridge_cfg dut (.*);

  typedef struct {
    bit         is_cfg;
    logic [7:0] exp_rd;
    logic [2:0] exp_route; // {dram, rom, drop}
    logic       exp_any;
    string      tag;
  } item_t;

  item_t q_exp[$];
  int    total = 0;
  int    bad   = 0;
  bit    finished = 0;

  logic [7:0] m44 = 8'h00;
  logic [7:0] m45 = 8'h00;

  function automatic logic [2:0] model_route(input logic [19:0] a, input logic w);
    int seg;
    if (a < 20'hE0000) return 3'b100;
    seg = int'((a - 20'hE0000) >> 15);
    if (!m44[4 + seg]) return w ? 3'b100 : 3'b010;
    if (!w) return 3'b100;
    return m45[0] ? 3'b001 : 3'b100;
  endfunction

  task automatic push_mem(input string tag);
    item_t it;
    it.is_cfg    = 0;
    it.exp_rd    = 8'h00;
    it.exp_route = model_route(mem_addr, mem_wr);
    it.exp_any   = |m44[7:4];
    it.tag       = tag;
    q_exp.push_back(it);
  endtask

  task automatic probe_mem(input logic [19:0] a, input logic w, input string tag);
    @(negedge clk);
    mem_addr = a;
    mem_wr   = w;
    push_mem(tag);
  endtask

  task automatic probe_cfg(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    cfg_addr     = a;
    it.is_cfg    = 1;
    it.exp_rd    = e;
    it.exp_route = 3'b000;
    it.exp_any   = 1'b0;
    it.tag       = tag;
    q_exp.push_back(it);
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
    if (a == 8'h44) m44 = d;
    if (a == 8'h45) m45 = d;
  endtask

  // R11: probe during the strobe cycle (old routing), then the next cycle (new routing)
  task automatic write_and_probe(input logic [7:0] a, input logic [7:0] d,
                                 input logic [19:0] ma, input logic w);
    @(negedge clk);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_we    = 1'b1;
    mem_addr  = ma;
    mem_wr    = w;
    push_mem("R11 strobe cycle keeps old routing");
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 8'h44) m44 = d;
    if (a == 8'h45) m45 = d;
    push_mem("R11 next cycle uses new routing");
  endtask

  task automatic probe_all_segs(input logic w, input string tag);
    for (int s = 0; s < 4; s++) begin
      probe_mem(20'hE0000 + 20'(s) * 20'h08000 + 20'h00123, w, tag);
      probe_mem(20'hE7FFF + 20'(s) * 20'h08000, w, tag);
    end
  endtask

  // monitor: pops one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_exp.size() > 0) begin
        item_t it;
        it = q_exp.pop_front();
        total++;
        if (it.is_cfg) begin
          if (cfg_rdata !== it.exp_rd) begin
            bad++;
            $display("FAIL %s: addr=%02h rdata=%02h expected=%02h", it.tag, cfg_addr, cfg_rdata, it.exp_rd);
          end
        end else if ({sel_dram, sel_rom, wr_drop} !== it.exp_route || shadow_any !== it.exp_any) begin
          bad++;
          $display("FAIL %s: addr=%05h wr=%0b route=%03b any=%0b expected route=%03b any=%0b",
                   it.tag, mem_addr, mem_wr, {sel_dram, sel_rom, wr_drop}, shadow_any,
                   it.exp_route, it.exp_any);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_addr = 8'h00; cfg_we = 1'b0; cfg_wdata = 8'h00;
    mem_addr = 20'h00000; mem_wr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    probe_cfg(8'h00, 8'h39, "R1 id byte 0");
    probe_cfg(8'h01, 8'h10, "R1 id byte 1");
    probe_cfg(8'h02, 8'h96, "R1 id byte 2");
    probe_cfg(8'h03, 8'h04, "R1 id byte 3");
    probe_cfg(8'h04, 8'h07, "R1 command");
    probe_cfg(8'h05, 8'h00, "R1 command hi");
    probe_cfg(8'h06, 8'h80, "R1 status lo");
    probe_cfg(8'h07, 8'h02, "R1 status hi");
    probe_cfg(8'h08, 8'h02, "R1 revision");
    probe_cfg(8'h09, 8'h00, "R1 class 0");
    probe_cfg(8'h0A, 8'h00, "R1 class 1");
    probe_cfg(8'h0B, 8'h06, "R1 class 2");
    probe_cfg(8'h0E, 8'h00, "R1 header type");
    probe_cfg(8'h44, 8'h00, "R1 shadow reg");
    probe_cfg(8'h45, 8'h00, "R1 protect reg");
    probe_cfg(8'h80, 8'h00, "R1 other offset");

    // R4 / R9 unshadowed routing at reset
    probe_all_segs(1'b0, "R4 unshadowed read to ROM");
    probe_all_segs(1'b1, "R4 unshadowed write to DRAM");
    // R8 outside range
    probe_mem(20'hC8000, 1'b0, "R8 low read");
    probe_mem(20'hDFFFF, 1'b1, "R8 low write");

    // R3 read-only offsets
    cfg_write(8'h00, 8'hAA); probe_cfg(8'h00, 8'h39, "R3 offset 00 read-only");
    cfg_write(8'h03, 8'h5A); probe_cfg(8'h03, 8'h04, "R3 offset 03 read-only");
    cfg_write(8'h08, 8'hFF); probe_cfg(8'h08, 8'h02, "R3 offset 08 read-only");
    cfg_write(8'h0E, 8'h80); probe_cfg(8'h0E, 8'h00, "R3 offset 0E read-only");
    cfg_write(8'h3F, 8'h77); probe_cfg(8'h3F, 8'h00, "R3 offset 3F read-only");

    // R2 writable offsets
    cfg_write(8'h04, 8'h55); probe_cfg(8'h04, 8'h55, "R2 offset 04");
    cfg_write(8'h07, 8'hC3); probe_cfg(8'h07, 8'hC3, "R2 offset 07");
    cfg_write(8'h40, 8'h9E); probe_cfg(8'h40, 8'h9E, "R2 offset 40");
    cfg_write(8'hFF, 8'h11); probe_cfg(8'hFF, 8'h11, "R2 offset FF");

    // R7 each bit maps to its own segment; R11 timing on every change
    write_and_probe(8'h44, 8'h10, 20'hE0000, 1'b0);
    probe_all_segs(1'b0, "R7 bit4 only");
    write_and_probe(8'h44, 8'h20, 20'hE8000, 1'b0);
    probe_all_segs(1'b0, "R7 bit5 only");
    write_and_probe(8'h44, 8'h40, 20'hF0000, 1'b0);
    probe_all_segs(1'b0, "R7 bit6 only");
    write_and_probe(8'h44, 8'h80, 20'hF8000, 1'b0);
    probe_all_segs(1'b0, "R7 bit7 only");
    cfg_write(8'h44, 8'h0F);
    probe_all_segs(1'b0, "R7 low bits no effect, R9 any low");

    // R5 / R6 shadowed segments
    cfg_write(8'h44, 8'hF0);
    probe_all_segs(1'b0, "R5 shadowed read to DRAM");
    probe_all_segs(1'b1, "R6 shadowed write unprotected");
    write_and_probe(8'h45, 8'h01, 20'hF4000, 1'b1);
    probe_all_segs(1'b1, "R6 shadowed write protected");
    probe_all_segs(1'b0, "R5 protected read to DRAM");
    probe_mem(20'hD0000, 1'b1, "R8 outside with protect");
    probe_cfg(8'h45, 8'h01, "R2 protect readback");

    cfg_write(8'h44, 8'h50);
    probe_all_segs(1'b1, "R6 mixed shadow protected writes");
    probe_all_segs(1'b0, "R4 mixed shadow reads");
    write_and_probe(8'h45, 8'h00, 20'hF0000, 1'b1);
    probe_cfg(8'h44, 8'h50, "R2 shadow readback");

    repeat (3) @(negedge clk);
    summary();
  end

endmodule